// File: doc/BRIEF.md
# IEC 60958 Subframe Word Formatter

This block sits in the audio path of a display transmitter. It turns a stream of 32-bit audio words into the subframe words that the transmitter's audio packetiser expects. Words arrive over a valid/ready handshake, one word per beat. They are interleaved by channel: every channel of a frame in turn, then the next frame. Each formatted word leaves through a single output register that also has a valid/ready handshake.

There are two input formats. In linear mode the input carries a 24-bit sample in its low bits. The block attaches three things to it:
- the channel-status bit for the current frame and channel, which it reads from a 192-entry status store;
- a block-start marker on the first word of every 192-frame block;
- an even-parity bit.

In pass-through mode the input is already a full subframe, with the P, C, U and V flags at the top and a preamble code at the bottom. The block only moves these fields into the output layout.

The status store is filled through a plain write port. A restart pulse returns the frame and channel position to zero and captures the format and the channel count. Changes to the format or the count made while streaming are held off until the next restart.

Top module: `iec_subframe_fmt`

## Requirements
- R1: After reset or a `restart` pulse, `out_valid` is 0. The next accepted word is treated as frame 0, channel 0. `in_ready` is 0 during the `restart` cycle.
- R2: In linear mode (`cfg_mode`=0), output bits 23:0 equal input bits 23:0. Output bits 31:29, 25 and 24 are 0, whatever the input's top byte holds.
- R3: In linear mode, output bit 26 equals the status-store bit for the current frame index and channel index. Store entry f holds, in bit c, the status bit for channel c.
- R4: In linear mode, output bit 28 is 1 exactly on the word of frame 0, channel 0, and is 0 on every other word.
- R5: In linear mode, output bit 27 is the XOR of output bits 26:0, so bits 27:0 together hold an even number of ones.
- R6: The channel index counts 0 up to count-1. After the last channel of a frame is accepted, the frame index advances by one. The frame index wraps from 191 to 0, so the block-start bit recurs every 192 × count words.
- R7: In pass-through mode (`cfg_mode`=1), output bits 27:0 equal input bits 31:4, output bit 28 equals input bit 3, and output bits 31:29 are 0.
- R8: The captured channel count is `cfg_lanes` limited to the range 2 to 8: a request below 2 gives 2, and a request above 8 gives 8.
- R9: `cfg_mode` and `cfg_lanes` are captured only while no word has been accepted since the last reset or restart, and always on a `restart` pulse. A change made after streaming has begun has no effect until the next `restart`.
- R10: While `out_valid`=1 and `out_ready`=0, `out_data` holds its value, `in_ready` is 0, and neither index advances.
- R11: A write through the status port (`cs_wr_en`, address, per-channel bits) replaces that store entry. Later frames at that address carry the new bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous pulse: zero the position and capture the configuration |
| cfg_mode | input | 1 | 0 = linear 24-bit samples, 1 = pre-formatted subframes |
| cfg_lanes | input | 4 | Requested channel count (limited to 2..8) |
| cs_wr_en | input | 1 | Status store write strobe |
| cs_wr_addr | input | 8 | Status store frame address (0..191) |
| cs_wr_bits | input | 8 | Status bits for that frame, one per channel |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 32 | Input audio word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 32 | Formatted subframe word |

## Verification
The bench uses the default parameters: a 192-frame status block and up to 8 channels. With these values a full block wrap in stereo takes 384 beats, which fits easily in a directed run. A request of 15 channels exercises the upper limit, and a request of 0 exercises the lower limit. The bench loads the status store with a pattern that differs between neighbouring frames and channels. As a result, a wrong channel count, a stepping error or a wrong frame index changes bit 26 and bit 27 of the output, where a full-word comparison catches it.

// File: rtl/iec_fmt_pkg.sv
package iec_fmt_pkg;

  typedef enum logic {
    FMT_LINEAR  = 1'b0,
    FMT_PREPACK = 1'b1
  } fmt_mode_e;

  localparam int SUBFRAME_W = 32;

  // even parity over the 27 low bits, placed at bit 27
  function automatic logic par27(input logic [26:0] v);
    return ^v;
  endfunction

  function automatic logic [SUBFRAME_W-1:0] pack_linear(input logic [23:0] smp,
                                                        input logic        cs_bit,
                                                        input logic        blk_first);
    logic [SUBFRAME_W-1:0] w;
    w        = '0;
    w[23:0]  = smp;
    w[26]    = cs_bit;
    w[28]    = blk_first;
    w[27]    = par27(w[26:0]);
    return w;
  endfunction

  function automatic logic [SUBFRAME_W-1:0] pack_prepacked(input logic [SUBFRAME_W-1:0] raw);
    logic [SUBFRAME_W-1:0] w;
    w        = '0;
    w[27:0]  = raw[31:4];
    w[28]    = raw[3];
    return w;
  endfunction

endpackage

// File: rtl/iec_cs_store.sv
module iec_cs_store #(
  parameter int FRAMES = 192,
  parameter int LANES  = 8,
  localparam int AW    = $clog2(FRAMES),
  localparam int LW    = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [LANES-1:0] wr_bits,
  input  logic [AW-1:0]    rd_frame,
  input  logic [LW-1:0]    rd_lane,
  output logic             rd_bit
);
  localparam logic [AW-1:0] TOP_ADDR = AW'(FRAMES - 1);

  logic [LANES-1:0] mem [FRAMES];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr <= TOP_ADDR)) mem[wr_addr] <= wr_bits;
  end

  logic [LANES-1:0] row;
  assign row    = mem[rd_frame];
  assign rd_bit = row[rd_lane];

endmodule

// File: rtl/iec_frame_seq.sv
module iec_frame_seq
  import iec_fmt_pkg::*;
#(
  parameter int FRAMES = 192,
  parameter int MAX_CH = 8,
  localparam int AW    = $clog2(FRAMES),
  localparam int LW    = $clog2(MAX_CH),
  localparam int CW    = $clog2(MAX_CH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          beat,
  input  logic          cfg_mode,
  input  logic [CW-1:0] cfg_lanes,
  output fmt_mode_e     mode_q,
  output logic [CW-1:0] lanes_q,
  output logic [AW-1:0] frame_idx,
  output logic [LW-1:0] lane_idx,
  output logic          blk_first
);
  localparam logic [AW-1:0] FRAME_TOP = AW'(FRAMES - 1);
  localparam logic [CW-1:0] MIN_LANES = CW'(2);
  localparam logic [CW-1:0] MAX_LANES = CW'(MAX_CH);

  function automatic logic [CW-1:0] limit_lanes(input logic [CW-1:0] req);
    if (req < MIN_LANES) return MIN_LANES;
    if (req > MAX_LANES) return MAX_LANES;
    return req;
  endfunction

  logic active;
  logic lane_last;
  logic frame_last;
  logic frame_step;

  assign lane_last  = (CW'(lane_idx) == (lanes_q - CW'(1)));
  assign frame_last = (frame_idx == FRAME_TOP);
  assign frame_step = beat && lane_last;
  assign blk_first  = (frame_idx == '0) && (lane_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      mode_q    <= FMT_LINEAR;
      lanes_q   <= MIN_LANES;
      frame_idx <= '0;
      lane_idx  <= '0;
    end else if (restart) begin
      active    <= 1'b0;
      mode_q    <= fmt_mode_e'(cfg_mode);
      lanes_q   <= limit_lanes(cfg_lanes);
      frame_idx <= '0;
      lane_idx  <= '0;
    end else begin
      if (!active) begin
        mode_q  <= fmt_mode_e'(cfg_mode);
        lanes_q <= limit_lanes(cfg_lanes);
      end
      if (beat) begin
        active <= 1'b1;
        if (lane_last) begin
          lane_idx  <= '0;
          frame_idx <= frame_last ? '0 : frame_idx + AW'(1);
        end else begin
          lane_idx <= lane_idx + LW'(1);
        end
      end
    end
  end

  assert_lane_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'(lane_idx) < lanes_q) && (lanes_q >= MIN_LANES) && (lanes_q <= MAX_LANES));

  assert_frame_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_step && frame_last && !restart) |=> (frame_idx == '0) && (lane_idx == '0));

  assert_no_step_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && !restart) |=> ($stable(frame_idx) && $stable(lane_idx)));

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !restart) |=> ($stable(mode_q) && $stable(lanes_q)));

endmodule

// File: rtl/iec_word_pack.sv
module iec_word_pack
  import iec_fmt_pkg::*;
(
  input  fmt_mode_e               mode,
  input  logic [SUBFRAME_W-1:0]   raw,
  input  logic                    cs_bit,
  input  logic                    blk_first,
  output logic [SUBFRAME_W-1:0]   word
);
  always_comb begin
    if (mode == FMT_PREPACK) word = pack_prepacked(raw);
    else                     word = pack_linear(raw[23:0], cs_bit, blk_first);
  end
endmodule

// File: rtl/iec_subframe_fmt.sv
module iec_subframe_fmt
  import iec_fmt_pkg::*;
#(
  parameter int FRAMES = 192,
  parameter int MAX_CH = 8,
  localparam int AW    = $clog2(FRAMES),
  localparam int LW    = $clog2(MAX_CH),
  localparam int CW    = $clog2(MAX_CH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart,
  input  logic                  cfg_mode,
  input  logic [CW-1:0]         cfg_lanes,
  input  logic                  cs_wr_en,
  input  logic [AW-1:0]         cs_wr_addr,
  input  logic [MAX_CH-1:0]     cs_wr_bits,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [SUBFRAME_W-1:0] in_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [SUBFRAME_W-1:0] out_data
);
  fmt_mode_e             mode_q;
  logic [CW-1:0]         lanes_q;
  logic [AW-1:0]         frame_idx;
  logic [LW-1:0]         lane_idx;
  logic                  blk_first;
  logic                  cs_bit;
  logic                  beat;
  logic [SUBFRAME_W-1:0] word;
  logic                  out_linear_q;

  assign in_ready = !restart && (!out_valid || out_ready);
  assign beat     = in_valid && in_ready;

  iec_frame_seq #(.FRAMES(FRAMES), .MAX_CH(MAX_CH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .beat      (beat),
    .cfg_mode  (cfg_mode),
    .cfg_lanes (cfg_lanes),
    .mode_q    (mode_q),
    .lanes_q   (lanes_q),
    .frame_idx (frame_idx),
    .lane_idx  (lane_idx),
    .blk_first (blk_first)
  );

  iec_cs_store #(.FRAMES(FRAMES), .LANES(MAX_CH)) u_cs (
    .clk      (clk),
    .wr_en    (cs_wr_en),
    .wr_addr  (cs_wr_addr),
    .wr_bits  (cs_wr_bits),
    .rd_frame (frame_idx),
    .rd_lane  (lane_idx),
    .rd_bit   (cs_bit)
  );

  iec_word_pack u_pack (
    .mode      (mode_q),
    .raw       (in_data),
    .cs_bit    (cs_bit),
    .blk_first (blk_first),
    .word      (word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_linear_q <= 1'b0;
    end else if (restart) begin
      out_valid <= 1'b0;
    end else if (beat) begin
      out_valid    <= 1'b1;
      out_data     <= word;
      out_linear_q <= (mode_q == FMT_LINEAR);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !restart) |=> (out_valid && $stable(out_data)));

  assert_restart_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !out_valid);

  assert_even_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_linear_q) |-> ($countones(out_data[27:0]) % 2 == 0));

  assert_linear_spare_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_linear_q) |-> (out_data[31:29] == 3'b000 && out_data[25:24] == 2'b00));

endmodule

// File: tb/tb_iec_subframe_fmt.sv
module tb_iec_subframe_fmt;
  localparam int CLK_PERIOD = 10;
  localparam int FRAMES     = 192;
  localparam int MAX_CH     = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic        cfg_mode = 1'b0;
  logic [3:0]  cfg_lanes = 4'd2;
  logic        cs_wr_en = 1'b0;
  logic [7:0]  cs_wr_addr = '0;
  logic [7:0]  cs_wr_bits = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [7:0] cs_model [FRAMES];
  int bf, bc, bn;
  bit bsub;
  logic [31:0] last_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  iec_subframe_fmt #(.FRAMES(FRAMES), .MAX_CH(MAX_CH)) dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cfg_mode(cfg_mode),
    .cfg_lanes(cfg_lanes), .cs_wr_en(cs_wr_en), .cs_wr_addr(cs_wr_addr),
    .cs_wr_bits(cs_wr_bits), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit pat_bit(input int f, input int c);
    return ((f + 2 * c) % 3) == 0;
  endfunction

  function automatic logic [31:0] model_word(input logic [31:0] din);
    logic [31:0] w;
    int ones;
    w = 32'h0;
    if (bsub) begin
      for (int i = 0; i < 28; i++) w[i] = din[i + 4];
      w[28] = din[3];
    end else begin
      w[23:0] = din[23:0];
      w[26] = cs_model[bf][bc];
      w[28] = (bf == 0 && bc == 0);
      ones = 0;
      for (int i = 0; i < 27; i++) ones += int'(w[i]);
      w[27] = ones[0];
    end
    return w;
  endfunction

  function automatic int limit(input int r);
    if (r < 2) return 2;
    if (r > MAX_CH) return MAX_CH;
    return r;
  endfunction

  task automatic step_model();
    if (bc == bn - 1) begin
      bc = 0;
      bf = (bf == FRAMES - 1) ? 0 : bf + 1;
    end else bc++;
  endtask

  task automatic write_cs(input int f, input logic [7:0] bits);
    @(negedge clk);
    cs_wr_en = 1'b1; cs_wr_addr = 8'(f); cs_wr_bits = bits;
    cs_model[f] = bits;
    @(negedge clk);
    cs_wr_en = 1'b0;
  endtask

  task automatic do_restart(input bit sub, input int lanes);
    @(negedge clk);
    cfg_mode = sub; cfg_lanes = 4'(lanes); restart = 1'b1;
    #1 check(in_ready == 1'b0, "R1 ready low in restart", {31'b0, in_ready}, 32'h0);
    @(negedge clk);
    restart = 1'b0;
    check(out_valid == 1'b0, "R1 out_valid after restart", {31'b0, out_valid}, 32'h0);
    bf = 0; bc = 0; bn = limit(lanes); bsub = sub;
  endtask

  task automatic push(input logic [31:0] din, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_data = din;
    last_exp = model_word(din);
    @(posedge clk);
    #1 in_valid = 1'b0;
    check(out_valid && out_data == last_exp, req, out_data, last_exp);
    step_model();
  endtask

  task automatic t_reset();
    #1 check(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset state",
             {30'b0, out_valid, in_ready}, 32'h1);
  endtask

  task automatic t_load();
    for (int f = 0; f < FRAMES; f++) begin
      logic [7:0] b;
      for (int c = 0; c < 8; c++) b[c] = pat_bit(f, c);
      write_cs(f, b);
    end
  endtask

  task automatic t_linear_stereo();
    do_restart(1'b0, 2);
    push(32'hA5FF_FFFF, "R2 R3 R4 R5 linear top byte dropped");
    push(32'h0000_0000, "R2 R3 R5 linear zero");
    push(32'h7F12_3456, "R2 R3 R5 linear");
    push(32'h0080_0001, "R2 R3 R5 linear");
    push(32'hFF00_0000, "R2 R3 R5 linear");
    push(32'h00AA_AAAA, "R2 R3 R5 linear");
  endtask

  task automatic t_wrap();
    do_restart(1'b0, 2);
    for (int i = 0; i < 2 * FRAMES; i++) push(32'(i * 7919), "R6 block walk");
    push(32'h0012_3400, "R6 wrap word");
    check(out_data[28] == 1'b1, "R6 block start recurs", {31'b0, out_data[28]}, 32'h1);
    push(32'h0055_6600, "R4 R6 after wrap");
    check(out_data[28] == 1'b0, "R4 no start on channel 1", {31'b0, out_data[28]}, 32'h0);
  endtask

  task automatic t_prepacked();
    do_restart(1'b1, 2);
    push(32'hF000_0008, "R7 flags and block start");
    push(32'h0ABC_DEF4, "R7 even preamble");
    push(32'h1234_5672, "R7 odd preamble");
    push(32'hFFFF_FFFF, "R7 all ones");
  endtask

  task automatic t_clamp();
    do_restart(1'b0, 0);
    for (int i = 0; i < 5; i++) push(32'(i + 32'h100), "R8 low clamp to 2");
    do_restart(1'b0, 15);
    for (int i = 0; i < 18; i++) push(32'(i * 31), "R8 high clamp to 8");
    do_restart(1'b0, 5);
    for (int i = 0; i < 12; i++) push(32'(i * 977), "R6 R8 five lanes");
  endtask

  task automatic t_frozen();
    do_restart(1'b0, 2);
    push(32'h0011_1111, "R9 first word");
    @(negedge clk);
    cfg_mode = 1'b1; cfg_lanes = 4'd4;
    for (int i = 0; i < 5; i++) push(32'(i * 4099), "R9 config held while streaming");
    do_restart(1'b1, 4);
    push(32'h1234_5678, "R9 config taken at restart");
    push(32'h8765_4321, "R9 config taken at restart");
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    do_restart(1'b0, 3);
    push(32'h0000_0ABC, "R10 before stall");
    held = last_exp;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 32'h00DE_F012;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #1 check(out_valid && out_data == held && !in_ready, "R10 hold while stalled",
               out_data, held);
    end
    last_exp = model_word(32'h00DE_F012);
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    check(out_valid && out_data == last_exp, "R10 no index step while stalled", out_data, last_exp);
    step_model();
    push(32'h0033_3333, "R10 after stall");
  endtask

  task automatic t_cs_write();
    write_cs(0, ~cs_model[0]);
    write_cs(1, 8'h5A);
    do_restart(1'b0, 8);
    for (int i = 0; i < 16; i++) push(32'(i * 131), "R11 rewritten status");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_load();
    t_linear_stereo();
    t_wrap();
    t_prepacked();
    t_clamp();
    t_frozen();
    t_backpressure();
    t_cs_write();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule